// File: doc/BRIEF.md
# Direct-Mapped Line Store with Tag Lookup

This block is the storage and lookup core of one level-one cache (instruction or data). It keeps 128 lines of eight 32-bit words in a synchronous dual-ported RAM, each line packed into a single 271-bit entry with its tag and a valid flag. The processor side presents a 32-bit word address. The line index goes to the RAM in that cycle. One cycle later the stored tag and valid flag are compared, and the requested word is selected from the line.

The second port belongs to a refill or update agent. It writes a whole line together with its tag, which marks the line valid. It can also invalidate a single line. The block reports hit or miss for each lookup. It also drives a fetch stall that is the miss result delayed through a register, which keeps the tag comparator out of the stall fan-out path. SDRAM traffic, refill sequencing and pipeline control are left to neighbouring blocks.

Top module: `dm_line_cache`

## Requirements
- R1: The store holds 128 independent lines of eight 32-bit words each, 1024 words in all. Writing one line never changes the contents of another.
- R2: A lookup address is split into three fields. Bits [2:0] select the word, bits [9:3] select the line, and bits [23:10] are the 14-bit tag to match. Word address 0x001234 therefore reads word 4 of line 70 under tag 4.
- R3: Lookup address bits [31:24] have no effect on hit, miss or the returned word.
- R4: A lookup presented with `lookupValid` high at clock edge t produces `respValid`, `respHit`/`respMiss` and `respWord` during the cycle after edge t. With no lookup, `respValid`, `respHit` and `respMiss` are all low.
- R5: A response is a hit only if the stored line is valid and its stored tag equals the address tag. Any other response is a miss, and exactly one of `respHit` and `respMiss` is high while `respValid` is high.
- R6: `fetchStall` is high during the cycle after a miss response and low during the cycle after any cycle without a miss response.
- R7: During reset and after it, every lookup misses until a line has been written through the update port, whatever the RAM contents are.
- R8: `updWrEn` high at an edge stores `updLine` and `updTag` at line `updIndex` and marks the line valid. A later lookup of that line with the same tag hits.
- R9: `updClrEn` high at an edge invalidates line `updIndex`, so later lookups of that line miss. Other lines keep their state.
- R10: If `updWrEn` and `updClrEn` are both high in the same cycle, the clear wins and the line ends up invalid.
- R11: Word n of a written line is taken from `updLine[32n+31:32n]`, so word 0 is the lowest 32 bits.
- R12: `respWord` is zero whenever `respHit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupAddr | input | 32 | Word address of the lookup |
| updWrEn | input | 1 | Write a full line and mark it valid |
| updClrEn | input | 1 | Invalidate a line |
| updIndex | input | 7 | Line targeted by the update port |
| updTag | input | 14 | Tag stored with a written line |
| updLine | input | 256 | Eight words of line data, word 0 lowest |
| respValid | output | 1 | A lookup response is present |
| respHit | output | 1 | The response is a hit |
| respMiss | output | 1 | The response is a miss |
| respWord | output | 32 | Selected word on a hit, zero otherwise |
| fetchStall | output | 1 | Registered miss, one cycle after the response |

## Verification
A lookup is driven on a falling edge, so the RAM captures it on the next rising edge. The hit/miss result and the word are sampled on the falling edge that follows, and `fetchStall` is sampled one falling edge later still. Update-port writes and clears are applied at one rising edge and are observed through a lookup issued in a later cycle. A back-to-back pair of lookups checks that the registered stall lags the combinational miss by exactly one cycle and does not carry over into the next response.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  // Strobes from the control to the datapath for the update port
  typedef struct packed {
    logic ramWrite;   // write the addressed entry
    logic validBit;   // valid flag stored with the entry
  } dmc_strobe_t;

endpackage

// File: rtl/dmc_ram.sv
// Simple dual-port synchronous RAM: one write port, one read port,
// one cycle read latency, read returns the old content on a collision.
module dmc_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 271,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/dmc_datapath.sv
// Address split, entry packing, tag compare and word select.
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  parameter int LINES  = 128,
  parameter int TAG_W  = 14,
  localparam int OFS_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(LINES),
  localparam int LINE_W  = WORD_W * WORDS,
  localparam int ENTRY_W = LINE_W + TAG_W + 1,
  localparam int USED_W  = OFS_W + IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmc_strobe_t       stb,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [IDX_W-1:0]  updIndex,
  input  logic [TAG_W-1:0]  updTag,
  input  logic [LINE_W-1:0] updLine,
  output logic [IDX_W-1:0]  lookupIdx,
  output logic              tagMatch,
  output logic              entryValid,
  output logic [WORD_W-1:0] lineWord
);

  logic [OFS_W-1:0]   lookupOfs;
  logic [TAG_W-1:0]   lookupTag;
  logic [OFS_W-1:0]   ofsQ;
  logic [TAG_W-1:0]   tagQ;
  logic [ENTRY_W-1:0] wrEntry;
  logic [ENTRY_W-1:0] rdEntry;
  logic [WORD_W-1:0]  words [WORDS];

  assign lookupOfs = lookupAddr[OFS_W-1:0];
  assign lookupIdx = lookupAddr[OFS_W+IDX_W-1:OFS_W];
  assign lookupTag = lookupAddr[USED_W-1:OFS_W+IDX_W];

  generate
    if (ADDR_W > USED_W) begin : g_high
      logic unusedHighBits;
      assign unusedHighBits = ^lookupAddr[ADDR_W-1:USED_W];
    end
  endgenerate

  // Entry layout: {data words, tag, valid}
  assign wrEntry = {updLine, updTag, stb.validBit};

  dmc_ram #(
    .DEPTH(LINES),
    .WIDTH(ENTRY_W)
  ) u_ram (
    .clk   (clk),
    .wrEn  (stb.ramWrite),
    .wrAddr(updIndex),
    .wrData(wrEntry),
    .rdAddr(lookupIdx),
    .rdData(rdEntry)
  );

  // Tag and offset follow the RAM read by one cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ofsQ <= '0;
      tagQ <= '0;
    end else begin
      ofsQ <= lookupOfs;
      tagQ <= lookupTag;
    end
  end

  assign entryValid = rdEntry[0];
  assign tagMatch   = (rdEntry[TAG_W:1] == tagQ);

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_word
      assign words[g] = rdEntry[1 + TAG_W + g*WORD_W +: WORD_W];
    end
  endgenerate

  assign lineWord = words[ofsQ];

endmodule

// File: rtl/dmc_control.sv
// Fill tracking, response qualification and the registered fetch stall.
module dmc_control
  import dmc_pkg::*;
#(
  parameter int LINES = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [IDX_W-1:0] lookupIdx,
  input  logic             updWrEn,
  input  logic             updClrEn,
  input  logic [IDX_W-1:0] updIndex,
  input  logic             tagMatch,
  input  logic             entryValid,
  output dmc_strobe_t      stb,
  output logic             respValid,
  output logic             respHit,
  output logic             respMiss,
  output logic             fetchStall
);

  // One flag per line, cleared by reset, so stale RAM content never hits
  logic [LINES-1:0] filledQ;
  logic             filledRdQ;
  logic             pendQ;
  logic             stallQ;

  always_comb begin
    stb.ramWrite = updWrEn | updClrEn;
    stb.validBit = updWrEn & ~updClrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filledQ   <= '0;
      filledRdQ <= 1'b0;
      pendQ     <= 1'b0;
      stallQ    <= 1'b0;
    end else begin
      pendQ     <= lookupValid;
      filledRdQ <= filledQ[lookupIdx];
      stallQ    <= respMiss;
      if (updClrEn)     filledQ[updIndex] <= 1'b0;
      else if (updWrEn) filledQ[updIndex] <= 1'b1;
    end
  end

  assign respValid  = pendQ;
  assign respHit    = pendQ & filledRdQ & entryValid & tagMatch;
  assign respMiss   = pendQ & ~respHit;
  assign fetchStall = stallQ;

endmodule

// File: rtl/dm_line_cache.sv
module dm_line_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  parameter int LINES  = 128,
  parameter int TAG_W  = 14,
  localparam int IDX_W  = $clog2(LINES),
  localparam int LINE_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              updWrEn,
  input  logic              updClrEn,
  input  logic [IDX_W-1:0]  updIndex,
  input  logic [TAG_W-1:0]  updTag,
  input  logic [LINE_W-1:0] updLine,
  output logic              respValid,
  output logic              respHit,
  output logic              respMiss,
  output logic [WORD_W-1:0] respWord,
  output logic              fetchStall
);

  dmc_strobe_t       stb;
  logic [IDX_W-1:0]  lookupIdx;
  logic              tagMatch;
  logic              entryValid;
  logic [WORD_W-1:0] lineWord;

  dmc_datapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS),
    .LINES(LINES), .TAG_W(TAG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .lookupAddr(lookupAddr),
    .updIndex  (updIndex),
    .updTag    (updTag),
    .updLine   (updLine),
    .lookupIdx (lookupIdx),
    .tagMatch  (tagMatch),
    .entryValid(entryValid),
    .lineWord  (lineWord)
  );

  dmc_control #(
    .LINES(LINES)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .lookupValid(lookupValid),
    .lookupIdx  (lookupIdx),
    .updWrEn    (updWrEn),
    .updClrEn   (updClrEn),
    .updIndex   (updIndex),
    .tagMatch   (tagMatch),
    .entryValid (entryValid),
    .stb        (stb),
    .respValid  (respValid),
    .respHit    (respHit),
    .respMiss   (respMiss),
    .fetchStall (fetchStall)
  );

  assign respWord = respHit ? lineWord : '0;

endmodule

// File: rtl/dm_line_cache_chk.sv
module dm_line_cache_chk (
  input logic clk,
  input logic rstN,
  input logic lookupValid,
  input logic respValid,
  input logic respHit,
  input logic respMiss,
  input logic fetchStall
);

  // R4: response one cycle after a lookup
  a_r4_resp_after_lookup: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  // R4: no response without a lookup
  a_r4_no_spurious_resp: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  // R5: exactly one verdict per response
  a_r5_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respHit ^ respMiss));

  // R4: idle cycles carry no verdict
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (!respHit && !respMiss));

  // R6: stall follows a miss
  a_r6_stall_after_miss: assert property (@(posedge clk) disable iff (!rstN)
    respMiss |=> fetchStall);

  // R6: no stall without a preceding miss
  a_r6_no_stall_otherwise: assert property (@(posedge clk) disable iff (!rstN)
    !respMiss |=> !fetchStall);

endmodule

bind dm_line_cache dm_line_cache_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lookupValid(lookupValid),
  .respValid  (respValid),
  .respHit    (respHit),
  .respMiss   (respMiss),
  .fetchStall (fetchStall)
);

// File: tb/tb_dm_line_cache.sv
module tb_dm_line_cache;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         lookupValid = 1'b0;
  logic [31:0]  lookupAddr = '0;
  logic         updWrEn = 1'b0;
  logic         updClrEn = 1'b0;
  logic [6:0]   updIndex = '0;
  logic [13:0]  updTag = '0;
  logic [255:0] updLine = '0;
  logic         respValid, respHit, respMiss, fetchStall;
  logic [31:0]  respWord;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #4 clk = ~clk;

  dm_line_cache dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .updWrEn(updWrEn), .updClrEn(updClrEn), .updIndex(updIndex), .updTag(updTag),
    .updLine(updLine), .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
    .respWord(respWord), .fetchStall(fetchStall)
  );

  function automatic logic [31:0] wordVal(int idx, int w, int seed);
    return {8'(seed), 8'(idx), 8'(w), 8'(idx ^ (w * 17) ^ seed)};
  endfunction

  function automatic logic [13:0] tagOf(int idx, int seed);
    return 14'((idx * 97 + seed * 13 + 5) % 16384);
  endfunction

  function automatic logic [31:0] mkAddr(logic [7:0] high, logic [13:0] tag, int idx, int w);
    return {high, tag, 7'(idx), 3'(w)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Update port action, applied at the next rising edge
  task automatic update(input bit wr, input bit clr, input int idx, input logic [13:0] tag, input int seed);
    updWrEn  = wr;
    updClrEn = clr;
    updIndex = 7'(idx);
    updTag   = tag;
    for (int w = 0; w < 8; w++) updLine[32*w +: 32] = wordVal(idx, w, seed);
    @(negedge clk);
    updWrEn  = 1'b0;
    updClrEn = 1'b0;
  endtask

  // Single lookup: response checked one edge later, stall one more edge later
  task automatic lookup(input logic [31:0] addr, input bit expHit, input logic [31:0] expWord, input string req);
    lookupValid = 1'b1;
    lookupAddr  = addr;
    @(negedge clk);
    lookupValid = 1'b0;
    chk(respValid === 1'b1, {req, " respValid"}, 32'(respValid), 32'd1);
    chk(respHit === expHit, {req, " respHit"}, 32'(respHit), 32'(expHit));
    chk(respMiss === !expHit, {req, " respMiss"}, 32'(respMiss), 32'(!expHit));
    chk(respWord === (expHit ? expWord : 32'd0), {req, " respWord (R12 when miss)"}, respWord, expHit ? expWord : 32'd0);
    @(negedge clk);
    chk(fetchStall === !expHit, {req, " fetchStall R6"}, 32'(fetchStall), 32'(!expHit));
    chk(respValid === 1'b0, {req, " idle respValid R4"}, 32'(respValid), 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R7: outputs quiet during reset
    chk(respValid === 1'b0 && respHit === 1'b0 && respMiss === 1'b0 && fetchStall === 1'b0,
        "R7 reset outputs", {28'd0, respValid, respHit, respMiss, fetchStall}, 32'd0);
    lookupValid = 1'b1;
    @(negedge clk);
    chk(respHit === 1'b0, "R7 lookup during reset", 32'(respHit), 32'd0);
    lookupValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // R7: every line misses after reset
    for (int i = 0; i < 128; i++) lookup(mkAddr(8'h00, tagOf(i, 1), i, i % 8), 1'b0, 32'd0, "R7 post-reset miss");

    // R8 R1 R11: fill every line
    for (int i = 0; i < 128; i++) update(1'b1, 1'b0, i, tagOf(i, 1), 1);

    // R1 R2 R3 R11: every word of every line, high address bits varied
    for (int i = 0; i < 128; i++)
      for (int w = 0; w < 8; w++)
        lookup(mkAddr(8'(i * 3 + w), tagOf(i, 1), i, w), 1'b1, wordVal(i, w, 1), "R1/R2/R3/R11 sweep hit");

    // R5: tag mismatch misses on every line
    for (int i = 0; i < 128; i++) lookup(mkAddr(8'h00, tagOf(i, 1) ^ 14'h0001, i, 0), 1'b0, 32'd0, "R5 tag mismatch");

    // R2: worked address example, line 70 tag 4 word 4
    update(1'b1, 1'b0, 70, 14'd4, 2);
    lookup(32'h0000_1234, 1'b1, wordVal(70, 4, 2), "R2 example 0x001234");
    lookup(32'hFF00_1234, 1'b1, wordVal(70, 4, 2), "R3 example high bits set");

    // R9: clear one line, neighbour untouched
    update(1'b0, 1'b1, 5, 14'd0, 0);
    lookup(mkAddr(8'h00, tagOf(5, 1), 5, 2), 1'b0, 32'd0, "R9 cleared line");
    lookup(mkAddr(8'h00, tagOf(6, 1), 6, 2), 1'b1, wordVal(6, 2, 1), "R9 neighbour kept");

    // R8: rewriting a cleared line makes it hit with new content
    update(1'b1, 1'b0, 5, tagOf(5, 3), 3);
    lookup(mkAddr(8'h00, tagOf(5, 3), 5, 7), 1'b1, wordVal(5, 7, 3), "R8 refill after clear");

    // R10: write and clear together leave the line invalid
    update(1'b1, 1'b1, 9, tagOf(9, 4), 4);
    lookup(mkAddr(8'h00, tagOf(9, 4), 9, 1), 1'b0, 32'd0, "R10 clear wins");
    lookup(mkAddr(8'h00, tagOf(9, 1), 9, 1), 1'b0, 32'd0, "R10 old tag gone");

    // R6: back-to-back hit then miss; stall lags the miss by one cycle
    lookupValid = 1'b1;
    lookupAddr  = mkAddr(8'h00, tagOf(6, 1), 6, 3);
    @(negedge clk);
    chk(respHit === 1'b1, "R6 pair first hit", 32'(respHit), 32'd1);
    chk(respWord === wordVal(6, 3, 1), "R6 pair first word", respWord, wordVal(6, 3, 1));
    lookupAddr = mkAddr(8'h00, 14'h3FFF, 6, 3);
    @(negedge clk);
    lookupValid = 1'b0;
    chk(respMiss === 1'b1, "R6 pair second miss", 32'(respMiss), 32'd1);
    chk(fetchStall === 1'b0, "R6 no stall after hit", 32'(fetchStall), 32'd0);
    @(negedge clk);
    chk(fetchStall === 1'b1, "R6 stall after miss", 32'(fetchStall), 32'd1);
    @(negedge clk);
    chk(fetchStall === 1'b0, "R6 stall drops", 32'(fetchStall), 32'd0);

    // R4: a valid address without lookupValid gives no response
    lookupAddr = mkAddr(8'h00, tagOf(6, 1), 6, 0);
    @(negedge clk);
    chk(respValid === 1'b0 && respHit === 1'b0 && respMiss === 1'b0, "R4 no lookup no response",
        {29'd0, respValid, respHit, respMiss}, 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule